// File: doc/BRIEF.md
# Configuration State Sequencer

This block steps a programmable device through four phases: waiting to start, loading its configuration, waking up, and running. It watches an active-low device reset request, an active-low program request and an init-ready input. In master mode it waits six extra internal clock cycles after init-ready rises before loading may begin. While loading, it counts configuration clock ticks from zero. It finishes the load only when the count equals a length value captured from the stream and an end-of-configuration strobe arrives together.

Out of the load, a fixed-length wake-up phase raises the done flag. The global internal reset and the user bidirectional buffer enable are released only when the running phase is reached. A load that ends too early, or that runs past its length, raises an error flag and sends the block back to the waiting phase. Which requests abort the sequence depends on the current phase.

Top module: `cfg_seq`

## Requirements
- R1: After the block reset, `phase` reads 00 (waiting). The phases follow the order 00 waiting, 01 loading, 10 wake-up, 11 running.
- R2: In loading, a low level on `dev_rst_n` or on `prog_n` at a clock edge moves the block to waiting (00) at that edge.
- R3: From waiting, the block enters loading only when `init_rdy` is high and both `dev_rst_n` and `prog_n` are high. Otherwise it stays in waiting.
- R4: In wake-up and running, a low `prog_n` moves the block to waiting at that edge. A low `dev_rst_n` has no effect in these phases.
- R5: With `master_sel` high, loading starts on the seventh edge at which `init_rdy` is seen high in waiting, which is six edges later than with `master_sel` low. With `master_sel` low, loading starts on the first such edge.
- R6: The tick counter reads zero on entry to loading. It then rises by one at each edge where `cfg_tick` is high.
- R7: The load completes, and the block enters wake-up, at an edge where `eoc_stb` is high, a length has been captured, and the tick count equals that length.
- R8: `gsr_n` and `bidi_oe` are low in every phase except running, where both are high. `done` is high in wake-up and running and low otherwise.
- R9: The first `len_stb` in a loading phase captures `len_val`. Later strobes in the same phase are ignored.
- R10: In loading, each of the following sends the block to waiting with `cfg_err` set: an `eoc_stb` without a count match, or a `cfg_tick` while the count already equals the captured length and no `eoc_stb` is present. `cfg_err` clears on the next entry to loading.
- R11: Wake-up lasts exactly `WAKE_CYC` clock cycles before the block enters running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| dev_rst_n | input | 1 | Active-low device reset request |
| prog_n | input | 1 | Active-low program request |
| init_rdy | input | 1 | Init-ready level |
| master_sel | input | 1 | 1 selects master mode with the extended wait |
| cfg_tick | input | 1 | One configuration clock tick |
| len_stb | input | 1 | Length field strobe |
| len_val | input | LEN_W | Length field value |
| eoc_stb | input | 1 | End-of-configuration frame strobe |
| phase | output | 2 | Current phase code |
| gsr_n | output | 1 | Global internal reset, low holds user flip-flops |
| bidi_oe | output | 1 | User bidirectional buffer enable |
| done | output | 1 | Configuration done flag |
| cfg_err | output | 1 | Load error flag |

## Verification
The bench builds the block with `LEN_W` = 4, `WAKE_CYC` = 4 and the master extension of six cycles. With these values, every length from 0 to 9 can be swept against every end-strobe position from zero ticks up to one tick past the length. That sweep covers matching completions, early end strobes and overruns arithmetically. The small wake-up length makes it practical to count every wake-up cycle, and the short master wait lets the bench check each edge of it against slave mode.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [1:0] {
    PH_WAIT = 2'b00,
    PH_LOAD = 2'b01,
    PH_WAKE = 2'b10,
    PH_RUN  = 2'b11
  } cfg_phase_t;
endpackage

// File: rtl/cfg_seq_tmr.sv
module cfg_seq_tmr #(
  parameter int LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == LIM);

  always_comb begin
    if (!run)               cnt_d = '0;
    else if (cnt_q == LIM)  cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tmr_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  assert_tmr_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/cfg_seq_lencnt.sv
module cfg_seq_lencnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_load,
  input  logic             tick,
  input  logic             len_stb,
  input  logic [LEN_W-1:0] len_in,
  input  logic             eoc_stb,
  output logic             complete,
  output logic             fault
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             have_q, have_d;
  logic             match;

  assign match    = have_q && (cnt_q == len_q);
  assign complete = in_load && eoc_stb && match;
  assign fault    = in_load && ((eoc_stb && !match) || (tick && match && !eoc_stb));

  always_comb begin
    cnt_d  = cnt_q;
    len_d  = len_q;
    have_d = have_q;
    if (!in_load) begin
      cnt_d  = '0;
      have_d = 1'b0;
    end else begin
      if (tick) cnt_d = cnt_q + 1'b1;
      if (len_stb && !have_q) begin
        len_d  = len_in;
        have_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= '0;
      have_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      have_q <= have_d;
      if (in_load && len_stb && !have_q) len_q <= len_d;
    end
  end

  assert_cnt_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_load |=> cnt_q == '0);
  assert_len_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    have_q && in_load |=> $stable(len_q));
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int MASTER_EXT = 6,
  parameter int WAKE_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_rst_n,
  input  logic             prog_n,
  input  logic             init_rdy,
  input  logic             master_sel,
  input  logic             cfg_tick,
  input  logic             len_stb,
  input  logic [LEN_W-1:0] len_val,
  input  logic             eoc_stb,
  output logic [1:0]       phase,
  output logic             gsr_n,
  output logic             bidi_oe,
  output logic             done,
  output logic             cfg_err
);
  localparam int WAKE_LIM = (WAKE_CYC < 1) ? 0 : WAKE_CYC - 1;

  cfg_phase_t ph_q, ph_d;
  logic       err_q, err_d;
  logic       ext_done, wake_done, ld_complete, ld_fault;
  logic       pins_idle, may_start;

  cfg_seq_tmr #(.LIMIT(MASTER_EXT)) u_ext (
    .clk(clk), .rst_n(rst_n),
    .run(ph_q == PH_WAIT && init_rdy),
    .expired(ext_done)
  );

  cfg_seq_tmr #(.LIMIT(WAKE_LIM)) u_wake (
    .clk(clk), .rst_n(rst_n),
    .run(ph_q == PH_WAKE),
    .expired(wake_done)
  );

  cfg_seq_lencnt #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n),
    .in_load(ph_q == PH_LOAD),
    .tick(cfg_tick), .len_stb(len_stb), .len_in(len_val), .eoc_stb(eoc_stb),
    .complete(ld_complete), .fault(ld_fault)
  );

  assign pins_idle = dev_rst_n && prog_n;
  assign may_start = pins_idle && init_rdy && (!master_sel || ext_done);

  always_comb begin
    ph_d  = ph_q;
    err_d = err_q;
    unique case (ph_q)
      PH_WAIT: if (may_start) begin
        ph_d  = PH_LOAD;
        err_d = 1'b0;
      end
      PH_LOAD: begin
        if (!pins_idle)       ph_d = PH_WAIT;
        else if (ld_complete) ph_d = PH_WAKE;
        else if (ld_fault) begin
          ph_d  = PH_WAIT;
          err_d = 1'b1;
        end
      end
      PH_WAKE: begin
        if (!prog_n)        ph_d = PH_WAIT;
        else if (wake_done) ph_d = PH_RUN;
      end
      PH_RUN: if (!prog_n) ph_d = PH_WAIT;
      default: ph_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_WAIT;
      err_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      err_q <= err_d;
    end
  end

  assign phase   = ph_q;
  assign gsr_n   = (ph_q == PH_RUN);
  assign bidi_oe = (ph_q == PH_RUN);
  assign done    = (ph_q == PH_WAKE) || (ph_q == PH_RUN);
  assign cfg_err = err_q;

  assert_abort_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LOAD) && !(dev_rst_n && prog_n) |=> ph_q == PH_WAIT);
  assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LOAD) && ($past(ph_q) == PH_WAIT) |-> $past(dev_rst_n && prog_n && init_rdy));
  assert_reset_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WAKE || ph_q == PH_RUN) && prog_n |=> ph_q != PH_WAIT);
  assert_finish_needs_eoc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WAKE) && ($past(ph_q) == PH_LOAD) |-> $past(eoc_stb));
  assert_err_only_from_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(ph_q) == PH_LOAD && ph_q == PH_WAIT);
endmodule

// File: tb/test_cfg_seq.sv
module test_cfg_seq;
  localparam int PERIOD = 10;
  localparam int LW     = 4;
  localparam int WAKE   = 4;
  localparam int EXT    = 6;

  logic clk = 1'b0;
  logic rst_n, dev_rst_n, prog_n, init_rdy, master_sel, cfg_tick, len_stb, eoc_stb;
  logic [LW-1:0] len_val;
  logic [1:0] phase;
  logic gsr_n, bidi_oe, done, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  cfg_seq #(.LEN_W(LW), .MASTER_EXT(EXT), .WAKE_CYC(WAKE)) i_cfg_seq (
    .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .prog_n(prog_n),
    .init_rdy(init_rdy), .master_sel(master_sel), .cfg_tick(cfg_tick),
    .len_stb(len_stb), .len_val(len_val), .eoc_stb(eoc_stb),
    .phase(phase), .gsr_n(gsr_n), .bidi_oe(bidi_oe), .done(done), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic outs(input string req, input int ph, input int g, input int oe,
                      input int d, input int e);
    chk({req, " phase"}, int'(phase), ph);
    chk({req, " gsr_n"}, int'(gsr_n), g);
    chk({req, " bidi_oe"}, int'(bidi_oe), oe);
    chk({req, " done"}, int'(done), d);
    chk({req, " cfg_err"}, int'(cfg_err), e);
  endtask

  task automatic enter_load(input bit m);
    init_rdy = 0; dev_rst_n = 1; prog_n = 1; master_sel = m;
    step();
    init_rdy = 1;
    if (m) begin
      for (int i = 0; i < EXT; i++) begin
        step();
        chk("R5 master wait", int'(phase), 0);
      end
    end
    step();
    chk("R5 R3 enter load", int'(phase), 1);
    chk("R10 error cleared", int'(cfg_err), 0);
    init_rdy = 0;
  endtask

  task automatic leave_by_prog();
    prog_n = 0;
    step();
    chk("R4 prog aborts", int'(phase), 0);
    prog_n = 1;
  endtask

  task automatic run_case(input int len, input int n);
    enter_load(1'b0);
    len_stb = 1; len_val = LW'(len);
    step();
    len_stb = 0;
    for (int i = 0; i < n; i++) begin
      cfg_tick = 1;
      step();
      cfg_tick = 0;
      if (i < len) chk("R6 counting", int'(phase), 1);
    end
    if (n > len) begin
      outs("R10 overrun", 0, 0, 0, 0, 1);
      return;
    end
    eoc_stb = 1;
    step();
    eoc_stb = 0;
    if (n == len) begin
      outs("R7 complete", 2, 0, 0, 1, 0);
      leave_by_prog();
    end else begin
      outs("R10 early eoc", 0, 0, 0, 0, 1);
    end
  endtask

  initial begin
    rst_n = 0; dev_rst_n = 1; prog_n = 1; init_rdy = 0; master_sel = 0;
    cfg_tick = 0; len_stb = 0; len_val = '0; eoc_stb = 0;
    step(); step();
    outs("R1 reset", 0, 0, 0, 0, 0);
    rst_n = 1;
    step();

    // R3: stays in waiting while either request is low
    dev_rst_n = 0; init_rdy = 1;
    step(); step();
    chk("R3 dev reset held", int'(phase), 0);
    dev_rst_n = 1; prog_n = 0;
    step(); step();
    chk("R3 prog held", int'(phase), 0);
    prog_n = 1; init_rdy = 0;
    step();
    chk("R3 no init_rdy", int'(phase), 0);

    // R2: abort during load by each request
    enter_load(1'b0);
    dev_rst_n = 0;
    step();
    outs("R2 dev reset abort", 0, 0, 0, 0, 0);
    dev_rst_n = 1;
    enter_load(1'b1);
    prog_n = 0;
    step();
    chk("R2 prog abort", int'(phase), 0);
    prog_n = 1;

    // Sweep all lengths against all end-strobe positions
    for (int l = 0; l < 10; l++)
      for (int n = 0; n <= l + 1; n++)
        run_case(l, n);

    // R9 / R11 / R8 / R4: second strobe ignored, full wake-up, running
    enter_load(1'b1);
    len_stb = 1; len_val = 4'd3;
    step();
    len_val = 4'd9;
    step();
    len_stb = 0;
    for (int i = 0; i < 3; i++) begin
      cfg_tick = 1; step(); cfg_tick = 0;
    end
    eoc_stb = 1; step(); eoc_stb = 0;
    outs("R9 R7 first length kept", 2, 0, 0, 1, 0);
    for (int i = 1; i < WAKE; i++) begin
      step();
      chk("R11 wake length", int'(phase), 2);
    end
    step();
    outs("R11 R8 running", 3, 1, 1, 1, 0);
    dev_rst_n = 0;
    step(); step();
    outs("R4 reset ignored in running", 3, 1, 1, 1, 0);
    dev_rst_n = 1;
    leave_by_prog();
    outs("R8 back to waiting", 0, 0, 0, 0, 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule